// File: doc/BRIEF.md
# Three-Channel Watchdog Timer

The block holds three independent 16-bit watchdog countdown channels and one shared action-mask byte behind a simple synchronous register bus. Each channel counts down once per tick, and a prescaler makes one tick every `TICK_DIV` clocks. The default of `TICK_DIV` gives one tick per tenth of a second at 100 MHz. Software starts a channel by writing its limit, which loads the down-counter. Software keeps the channel alive by reading the down-counter, and that read reloads the counter from the limit.

When a channel's counter reaches zero it stops and reports expired. The three channels act differently on expiry:

- Channel 0 raises a level interrupt.
- Channel 1 fires a CPU-only reset pulse.
- Channel 2 fires a whole-system reset pulse.

Setting a channel's bit in the mask byte suppresses only that channel's action. The counter and the status of a masked channel behave exactly as they do unmasked.

The bus carries a word address, two byte-lane enables and 16 data bits. Lane 0 is bits 7:0 and lane 1 is bits 15:8. Read data is combinational from the current state, and every side effect of an access takes place at the clock edge that ends the access cycle.

Top module: `tri_watchdog`

## Requirements
- R1: After reset every down-counter and every limit read 1, every channel status reads 0, the mask reads 0, and irqOut, cpuRstOut and sysRstOut are low.
- R2: A write to a channel's limit register with at least one lane enabled does four things at that edge. It updates only the enabled byte lanes of the limit (lane 0 = bits 7:0, lane 1 = bits 15:8), loads the down-counter with the resulting limit, sets running (status bit 0) and clears expired (status bit 1).
- R3: A tick occurs on every TICK_DIV-th clock after reset release. At each tick a running channel's counter decrements by one. When a tick arrives with the counter at 1 or 0, the counter becomes 0, running clears and expired sets. Running and expired are never both set.
- R4: A read of a channel's down-counter register returns the current count and reloads the counter from the limit at that edge. This reload leaves running and expired unchanged. A limit write or a counter read takes precedence over a tick in the same cycle.
- R5: Reads of the limit, status, mask and summary registers change no state.
- R6: irqOut is high exactly while channel 0 is expired and mask bit 0 is clear.
- R7: When channel 1 expires while mask bit 1 is clear, cpuRstOut goes high at that edge for RST_PULSE cycles. An expiry during an active pulse neither restarts nor extends it.
- R8: When channel 2 expires while mask bit 2 is clear, sysRstOut goes high at that edge for RST_PULSE cycles, with the same no-extension rule as R7.
- R9: Mask bit n = 1 suppresses only channel n's action. The channel still counts, still expires and still reports its status. The mask value before the expiry edge decides. Mask writes need lane 0, take bits 2:0 only, and bits 15:3 read 0.
- R10: The map uses word addresses: channel k at words 4k (counter), 4k+1 (limit) and 4k+2 (status); word 12 is the mask; word 13 is a summary holding the expired bits of channels 2..0 in bits 2..0. All other words read 0, and busRdata is 0 when no read is selected.
- R11: Accesses to one channel never alter the count, limit or status of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address |
| busBe | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational |
| irqOut | output | 1 | Channel 0 interrupt level |
| cpuRstOut | output | 1 | Channel 1 CPU reset pulse |
| sysRstOut | output | 1 | Channel 2 system reset pulse |

## Verification
The assertions check several properties on every cycle:

- running and expired never overlap;
- a limit write leaves its channel running;
- a set mask bit keeps the interrupt low;
- an unmasked expiry of channel 1 or 2 raises its reset pulse in the same edge;
- neither pulse stays high longer than its configured length.

Other behaviours show only in the bench's scenarios, where a behavioural model is compared against the outputs on every clock. These are:

- the exact tick count to expiry;
- the reload caused by a counter read;
- the byte-lane merge into the limit;
- that status and limit reads have no side effect;
- that masking leaves counting and status intact;
- the register map and the summary byte.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NCH    = 3;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;
  localparam int ADDR_W = 4;

  localparam logic [1:0] WIN_MISC = 2'd3;
  localparam logic [1:0] SUB_CNT  = 2'd0;
  localparam logic [1:0] SUB_LIM  = 2'd1;
  localparam logic [1:0] SUB_STAT = 2'd2;
  localparam logic [1:0] SUB_MASK = 2'd0;
  localparam logic [1:0] SUB_SUMM = 2'd1;

  typedef struct packed {
    logic [NCH-1:0]   limWr;
    logic [NCH-1:0]   kick;
    logic [LANES-1:0] lane;
    logic             maskWr;
    logic             rdEn;
    logic [1:0]       win;
    logic [1:0]       sub;
    logic             tick;
  } wdtStrb_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int TICK_DIV  = 10_000_000,
  parameter int RST_PULSE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LANES-1:0]  busBe,
  input  logic [NCH-1:1]    expEvt,
  input  logic              expCh0,
  input  logic [NCH-1:0]    maskQ,
  output wdtStrb_t          strb,
  output logic [NCH-1:0]    actOut
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int QW = $clog2(RST_PULSE + 1);

  logic [PW-1:0] preCnt;
  logic          tick;
  logic [1:0]    win, sub;

  assign win  = busAddr[3:2];
  assign sub  = busAddr[1:0];
  assign tick = (preCnt == PW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + PW'(1);
  end

  always_comb begin
    strb        = '0;
    strb.lane   = busBe;
    strb.tick   = tick;
    strb.win    = win;
    strb.sub    = sub;
    strb.rdEn   = busSel && !busWrite;
    strb.maskWr = busSel && busWrite && (win == WIN_MISC) && (sub == SUB_MASK) && busBe[0];
    for (int k = 0; k < NCH; k++) begin
      strb.limWr[k] = busSel && busWrite && (win == 2'(k)) && (sub == SUB_LIM) && (|busBe);
      strb.kick[k]  = busSel && !busWrite && (win == 2'(k)) && (sub == SUB_CNT);
    end
  end

  // channel 0: level interrupt; channels 1 and 2: fixed-length reset pulses
  assign actOut[0] = expCh0 && !maskQ[0];

  for (genvar k = 1; k < NCH; k++) begin : g_pulse
    logic [QW-1:0] pulseCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        pulseCnt <= '0;
      else if (expEvt[k] && !maskQ[k] && (pulseCnt == '0))
        pulseCnt <= QW'(RST_PULSE);
      else if (pulseCnt != '0)
        pulseCnt <= pulseCnt - QW'(1);
    end
    assign actOut[k] = (pulseCnt != '0);
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrb_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NCH-1:0]    expEvt,
  output logic [NCH-1:0]    runV,
  output logic [NCH-1:0]    expV,
  output logic [NCH-1:0]    maskQ
);
  logic [DATA_W-1:0] cntV [NCH];
  logic [DATA_W-1:0] limV [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [DATA_W-1:0] cnt, lim, limNext;
    logic              run, expd;

    always_comb begin
      limNext = lim;
      for (int b = 0; b < LANES; b++)
        if (strb.lane[b]) limNext[b*8 +: 8] = busWdata[b*8 +: 8];
    end

    assign expEvt[k] = strb.tick && run && !strb.limWr[k] && !strb.kick[k]
                       && (cnt <= DATA_W'(1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= DATA_W'(1);
        lim  <= DATA_W'(1);
        run  <= 1'b0;
        expd <= 1'b0;
      end else if (strb.limWr[k]) begin
        lim  <= limNext;
        cnt  <= limNext;
        run  <= 1'b1;
        expd <= 1'b0;
      end else if (strb.kick[k]) begin
        cnt <= lim;
      end else if (strb.tick && run) begin
        if (cnt <= DATA_W'(1)) begin
          cnt  <= '0;
          run  <= 1'b0;
          expd <= 1'b1;
        end else begin
          cnt <= cnt - DATA_W'(1);
        end
      end
    end

    assign cntV[k] = cnt;
    assign limV[k] = lim;
    assign runV[k] = run;
    assign expV[k] = expd;
  end

  logic [NCH-1:0] maskR;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskR <= '0;
    else if (strb.maskWr) maskR <= busWdata[NCH-1:0];
  end
  assign maskQ = maskR;

  always_comb begin
    busRdata = '0;
    if (strb.rdEn) begin
      if (strb.win == WIN_MISC) begin
        case (strb.sub)
          SUB_MASK: busRdata = DATA_W'(maskR);
          SUB_SUMM: busRdata = DATA_W'(expV);
          default:  busRdata = '0;
        endcase
      end else begin
        for (int k = 0; k < NCH; k++) begin
          if (strb.win == 2'(k)) begin
            case (strb.sub)
              SUB_CNT:  busRdata = cntV[k];
              SUB_LIM:  busRdata = limV[k];
              SUB_STAT: busRdata = DATA_W'({expV[k], runV[k]});
              default:  busRdata = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/tri_watchdog.sv
module tri_watchdog
  import wdt_pkg::*;
#(
  parameter int TICK_DIV  = 10_000_000,
  parameter int RST_PULSE = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [3:0]  busAddr,
  input  logic [1:0]  busBe,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        irqOut,
  output logic        cpuRstOut,
  output logic        sysRstOut
);
  wdtStrb_t       strb;
  logic [NCH-1:0] expEvt, runV, expV, maskQ, actOut;

  wdt_ctrl #(.TICK_DIV(TICK_DIV), .RST_PULSE(RST_PULSE)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busBe(busBe), .expEvt(expEvt[NCH-1:1]),
    .expCh0(expV[0]), .maskQ(maskQ), .strb(strb), .actOut(actOut)
  );

  wdt_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .expEvt(expEvt), .runV(runV), .expV(expV),
    .maskQ(maskQ)
  );

  assign irqOut    = actOut[0];
  assign cpuRstOut = actOut[1];
  assign sysRstOut = actOut[2];
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int RST_PULSE = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           busSel,
  input logic           busWrite,
  input logic [3:0]     busAddr,
  input logic [1:0]     busBe,
  input logic [NCH-1:0] runV,
  input logic [NCH-1:0] expV,
  input logic [NCH-1:0] maskQ,
  input logic           irqOut,
  input logic           cpuRstOut,
  input logic           sysRstOut
);
  localparam int HW = $clog2(RST_PULSE + 2);
  localparam logic [HW-1:0] HMAX = HW'(RST_PULSE + 1);

  logic [HW-1:0] cpuHi, sysHi;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuHi <= '0;
      sysHi <= '0;
    end else begin
      cpuHi <= !cpuRstOut ? '0 : (cpuHi == HMAX ? cpuHi : cpuHi + HW'(1));
      sysHi <= !sysRstOut ? '0 : (sysHi == HMAX ? sysHi : sysHi + HW'(1));
    end
  end

  assert_run_exp_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    (runV & expV) == '0);

  assert_limit_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == 4'd1 && busBe != 2'b00) |=> runV[0]);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    maskQ[0] |-> !irqOut);

  assert_cpu_pulse_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(expV[1]) && !$past(maskQ[1])) |-> cpuRstOut);

  assert_sys_pulse_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(expV[2]) && !$past(maskQ[2])) |-> sysRstOut);

  assert_cpu_pulse_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuHi <= HW'(RST_PULSE));

  assert_sys_pulse_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    sysHi <= HW'(RST_PULSE));
endmodule

bind tri_watchdog wdt_checker #(.RST_PULSE(RST_PULSE)) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busBe(busBe), .runV(runV), .expV(expV),
  .maskQ(maskQ), .irqOut(irqOut), .cpuRstOut(cpuRstOut), .sysRstOut(sysRstOut)
);

// File: tb/tri_watchdog_tb.sv
module tri_watchdog_tb_top;
  localparam int TDIV = 4;
  localparam int PUL  = 3;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [1:0]  busBe = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irqOut, cpuRstOut, sysRstOut;

  always #5 clk = ~clk;

  tri_watchdog #(.TICK_DIV(TDIV), .RST_PULSE(PUL)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .cpuRstOut(cpuRstOut),
    .sysRstOut(sysRstOut)
  );

  int nChecks = 0, nFails = 0;
  int cpuHigh = 0, sysHigh = 0;

  // behavioural reference model
  int mCnt[3], mLim[3], mPulse[3];
  bit mRun[3], mExp[3];
  int mMask = 0, mPre = 0;

  function automatic void modelReset();
    for (int k = 0; k < 3; k++) begin
      mCnt[k] = 1; mLim[k] = 1; mPulse[k] = 0; mRun[k] = 0; mExp[k] = 0;
    end
    mMask = 0; mPre = 0;
  endfunction

  initial modelReset();

  function automatic void modelStep();
    bit tick;
    bit evt[3];
    int win, sub, oldMask;
    tick = (mPre == TDIV - 1);
    mPre = tick ? 0 : mPre + 1;
    win = int'(busAddr[3:2]);
    sub = int'(busAddr[1:0]);
    oldMask = mMask;
    for (int k = 0; k < 3; k++) begin
      evt[k] = 0;
      if (busSel && busWrite && win == k && sub == 1 && busBe != 2'b00) begin
        if (busBe[0]) mLim[k] = (mLim[k] & 'hFF00) | int'(busWdata[7:0]);
        if (busBe[1]) mLim[k] = (mLim[k] & 'h00FF) | (int'(busWdata[15:8]) << 8);
        mCnt[k] = mLim[k]; mRun[k] = 1; mExp[k] = 0;
      end else if (busSel && !busWrite && win == k && sub == 0) begin
        mCnt[k] = mLim[k];
      end else if (tick && mRun[k]) begin
        if (mCnt[k] <= 1) begin
          mCnt[k] = 0; mRun[k] = 0; mExp[k] = 1; evt[k] = 1;
        end else mCnt[k] = mCnt[k] - 1;
      end
    end
    for (int k = 1; k < 3; k++) begin
      if (evt[k] && !oldMask[k] && mPulse[k] == 0) mPulse[k] = PUL;
      else if (mPulse[k] > 0) mPulse[k] = mPulse[k] - 1;
    end
    if (busSel && busWrite && win == 3 && sub == 0 && busBe[0])
      mMask = int'(busWdata[2:0]);
  endfunction

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else modelStep();
  end

  function automatic int modelRead(input logic [3:0] a);
    int win, sub;
    win = int'(a[3:2]);
    sub = int'(a[1:0]);
    if (win == 3) begin
      if (sub == 0) return mMask;
      if (sub == 1) return (int'(mExp[2]) << 2) | (int'(mExp[1]) << 1) | int'(mExp[0]);
      return 0;
    end
    if (sub == 0) return mCnt[win];
    if (sub == 1) return mLim[win];
    if (sub == 2) return (int'(mExp[win]) << 1) | int'(mRun[win]);
    return 0;
  endfunction

  function automatic void check(input int act, input int expv, input string tag);
    nChecks++;
    if (act != expv) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, expv, $time);
    end
  endfunction

  // per-cycle comparison of the action outputs
  always @(negedge clk) begin
    if (rstN) begin
      check(int'(irqOut), int'(mExp[0] && !mMask[0]), "R6 irqOut level");
      check(int'(cpuRstOut), int'(mPulse[1] > 0), "R7 cpuRstOut pulse");
      check(int'(sysRstOut), int'(mPulse[2] > 0), "R8 sysRstOut pulse");
    end else begin
      check(int'({irqOut, cpuRstOut, sysRstOut}), 0, "R1 outputs low in reset");
    end
    if (cpuRstOut) cpuHigh++;
    if (sysRstOut) sysHigh++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busBe = be; busWdata = d;
    @(posedge clk);
    #1 busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a; busBe = 2'b11;
    #1 check(int'(busRdata), modelRead(a), tag);
    @(posedge clk);
    #1 busSel = 0;
  endtask

  task automatic rdx(input logic [3:0] a, input int expv, input string tag);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a; busBe = 2'b11;
    #1 check(int'(busRdata), expv, tag);
    @(posedge clk);
    #1 busSel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    #1 check(int'(busRdata), 0, "R10 idle bus reads zero");

    // R1 reset state
    rdx(4'd1, 1, "R1 ch0 limit");
    rdx(4'd5, 1, "R1 ch1 limit");
    rdx(4'd9, 1, "R1 ch2 limit");
    rdx(4'd2, 0, "R1 ch0 status");
    rdx(4'd10, 0, "R1 ch2 status");
    rdx(4'd12, 0, "R1 mask");
    rdx(4'd13, 0, "R1 summary");
    rdx(4'd4, 1, "R1 ch1 counter");

    // R2 start, R3 countdown and expiry, R6 interrupt
    wr(4'd1, 2'b11, 16'd5);
    rdx(4'd2, 1, "R2 running after limit write");
    idle(6);
    rd(4'd1, "R5 limit read");
    rd(4'd2, "R5 status read");
    idle(30);
    rdx(4'd2, 2, "R3 ch0 expired");
    rdx(4'd13, 1, "R10 summary ch0");
    rd(4'd0, "R4 counter read while expired");
    rdx(4'd2, 2, "R4 reload keeps expired");

    // R9 mask field width, irq suppressed
    wr(4'd12, 2'b01, 16'hFFFF);
    rdx(4'd12, 7, "R9 mask upper bits ignored");
    idle(3);
    wr(4'd12, 2'b01, 16'h0000);

    // R2 restart clears expired
    wr(4'd1, 2'b11, 16'd100);
    rdx(4'd2, 1, "R2 restart clears expired");

    // R4 kicking channel 1
    wr(4'd5, 2'b11, 16'd6);
    for (int i = 0; i < 8; i++) begin
      idle(10);
      rd(4'd4, "R4 kick read value");
    end
    rdx(4'd6, 1, "R4 kicked channel still running");
    rd(4'd0, "R11 ch0 count unaffected");
    rdx(4'd2, 1, "R11 ch0 still running");

    // R7 channel 1 expiry
    idle(40);
    rdx(4'd6, 2, "R7 ch1 expired");
    check(cpuHigh, PUL, "R7 cpu reset pulse width");

    // R9 masked channel 2 still expires, no action
    wr(4'd12, 2'b01, 16'h0004);
    wr(4'd9, 2'b11, 16'd2);
    idle(20);
    rdx(4'd10, 2, "R9 masked ch2 expires");
    check(sysHigh, 0, "R9 masked ch2 no system reset");
    rdx(4'd13, 6, "R10 summary ch1 ch2");

    // R8 channel 2 unmasked, zero limit
    wr(4'd12, 2'b01, 16'h0000);
    wr(4'd9, 2'b11, 16'd0);
    idle(12);
    rdx(4'd10, 2, "R8 ch2 expired");
    check(sysHigh, PUL, "R8 system reset pulse width");

    // R2 lane merge
    wr(4'd1, 2'b01, 16'hAB12);
    rdx(4'd1, 'h0012, "R2 lane0 only");
    wr(4'd1, 2'b10, 16'hAB34);
    rdx(4'd1, 'hAB12, "R2 lane1 only");
    rd(4'd0, "R2 counter loaded");

    // R5 reads have no side effect on the counter
    idle(9);
    rd(4'd1, "R5 limit read");
    rd(4'd2, "R5 status read");
    rd(4'd12, "R5 mask read");
    rd(4'd13, "R5 summary read");
    rd(4'd0, "R5 counter unaffected by other reads");

    // R10 unmapped words, R9 upper lane mask write ignored
    rdx(4'd3, 0, "R10 unmapped word 3");
    rdx(4'd14, 0, "R10 unmapped word 14");
    wr(4'd12, 2'b10, 16'hFFFF);
    rdx(4'd12, 0, "R9 mask needs lane0");
    idle(4);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule